// File: doc/BRIEF.md
# Cartridge PRG Bank and Mirroring Latch

This block is the single control register of a simple cartridge address mapper. The CPU writes one byte anywhere in the upper half of its address space. The block stores that byte and derives two things from it. The first is the high program-ROM address bits for whichever 16 KB half of the 32 KB CPU ROM window is being accessed. The second is the nametable screen select for a picture-processor nametable quadrant. The register cannot be read back.

One control bit picks the banking layout. In one layout a 16 KB bank is mirrored into both halves of the window. In the other, a 32 KB bank fills the window and CPU address bit 14 chooses its half. The mirroring control has four settings: vertical, horizontal, single-screen 1, and a layout in which three quadrants share screen 0 while the fourth uses screen 1. The ROM size is a parameter: `PRG_BANKS16` is the count of 16 KB banks and must be a power of two. Bank numbers wrap modulo that count.

Top module: `prg_mirror_latch`

## Requirements
- R1: On a rising clock edge with `cpu_wr` high and `cpu_addr[15]` = 1, the register loads `cpu_data`. The new value drives the outputs from just after that edge.
- R2: A write strobe with `cpu_addr[15]` = 0 is ignored, and so is a clock edge with `cpu_wr` low. All outputs keep their previous mapping.
- R3: With stored bit 5 = 1, `prg_bank` equals stored bits 4:0 modulo `PRG_BANKS16`, for both values of `cpu_addr[14]`.
- R4: With stored bit 5 = 0, `prg_bank` equals {stored bits 4:1, `cpu_addr[14]`} modulo `PRG_BANKS16`. This is a 32 KB bank equal to bits 4:1.
- R5: `mirror_mode` equals stored bits 7:6. In mode 0, quadrants 0, 1 and 2 give `nt_screen` = 0 and quadrant 3 gives 1.
- R6: In mode 1 (vertical), `nt_screen` equals `ppu_quad[0]`, the horizontal position of the quadrant.
- R7: In mode 2 (horizontal), `nt_screen` equals `ppu_quad[1]`, the vertical position of the quadrant.
- R8: In mode 3, `nt_screen` is 1 for every quadrant.
- R9: While `rst_n` is low the register is zero. This selects 32 KB bank 0 (`prg_bank` = `cpu_addr[14]`) and mode 0.
- R10: `prg_bank` and `nt_screen` follow `cpu_addr[14]` and `ppu_quad` combinationally, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| ppu_quad | input | 2 | Nametable quadrant being accessed (bit 0 = right, bit 1 = bottom) |
| prg_bank | output | $clog2(PRG_BANKS16) | 16 KB bank index, i.e. ROM address bits above bit 13 |
| nt_screen | output | 1 | Selected nametable screen (0 or 1) |
| mirror_mode | output | 2 | Current mirroring mode code |

## Verification
The assertions check the following on every cycle:
- A decoded write lands in the mode on the next cycle.
- Undecoded cycles leave the mode unchanged.
- After a 32 KB write, the bank's low bit tracks CPU address bit 14.
- After a 16 KB write, the bank equals the wrapped field.
- Each mirroring mode produces its quadrant-to-screen relation.

Other behaviours show up only in the bench's scenarios:
- Wrap-around with bank fields wider than the ROM.
- A stored value surviving an ignored write, checked against every quadrant and both window halves.
- The state after a reset in the middle of a run.

// File: rtl/prgmir_pkg.sv
package prgmir_pkg;

  localparam int FIELD_W = 5;

  typedef enum logic [1:0] {
    MIR_TRI3  = 2'd0,
    MIR_VERT  = 2'd1,
    MIR_HORZ  = 2'd2,
    MIR_SOLO1 = 2'd3
  } mirror_e;

  typedef struct packed {
    mirror_e              mode;
    logic                 half16;
    logic [FIELD_W-1:0]   field;
  } cfg_t;

endpackage

// File: rtl/prgmir_reg.sv
module prgmir_reg
  import prgmir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  output cfg_t        cfg_q
);

  logic wr_hit;
  cfg_t cfg_d;

  // Only the ROM window (A15 high) decodes the register.
  always_comb begin
    wr_hit = cpu_wr && cpu_addr[15];
    cfg_d  = cfg_q;
    if (wr_hit) begin
      cfg_d = cfg_t'(cpu_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_hit) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/prgmir_bank.sv
module prgmir_bank
  import prgmir_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  cfg_t              cfg,
  input  logic              a14,
  output logic [BANK_W-1:0] bank
);

  logic [FIELD_W-1:0] full;

  // 16 KB layout: same bank in both halves. 32 KB layout: A14 is the low bit.
  always_comb begin
    if (cfg.half16) begin
      full = cfg.field;
    end else begin
      full = {cfg.field[FIELD_W-1:1], a14};
    end
  end

  generate
    if (BANK_W <= FIELD_W) begin : g_wrap
      assign bank = full[BANK_W-1:0];
    end else begin : g_extend
      assign bank = {{(BANK_W-FIELD_W){1'b0}}, full};
    end
  endgenerate

endmodule

// File: rtl/prgmir_ntsel.sv
module prgmir_ntsel
  import prgmir_pkg::*;
(
  input  mirror_e    mode,
  input  logic [1:0] quad,
  output logic       screen
);

  always_comb begin
    unique case (mode)
      MIR_TRI3:  screen = &quad;
      MIR_VERT:  screen = quad[0];
      MIR_HORZ:  screen = quad[1];
      MIR_SOLO1: screen = 1'b1;
      default:   screen = 1'b0;
    endcase
  end

endmodule

// File: rtl/prg_mirror_latch.sv
module prg_mirror_latch
  import prgmir_pkg::*;
#(
  parameter int PRG_BANKS16 = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [15:0]                    cpu_addr,
  input  logic [7:0]                     cpu_data,
  input  logic                           cpu_wr,
  input  logic [1:0]                     ppu_quad,
  output logic [$clog2(PRG_BANKS16)-1:0] prg_bank,
  output logic                           nt_screen,
  output logic [1:0]                     mirror_mode
);

  localparam int BANK_W = $clog2(PRG_BANKS16);

  cfg_t cfg_q;

  prgmir_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .cfg_q    (cfg_q)
  );

  prgmir_bank #(.BANK_W(BANK_W)) u_bank (
    .cfg  (cfg_q),
    .a14  (cpu_addr[14]),
    .bank (prg_bank)
  );

  prgmir_ntsel u_nt (
    .mode   (cfg_q.mode),
    .quad   (ppu_quad),
    .screen (nt_screen)
  );

  assign mirror_mode = cfg_q.mode;

endmodule

// File: rtl/prgmir_checker.sv
module prgmir_checker #(
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   cpu_addr,
  input logic [7:0]    cpu_data,
  input logic          cpu_wr,
  input logic [1:0]    ppu_quad,
  input logic [BW-1:0] prg_bank,
  input logic          nt_screen,
  input logic [1:0]    mirror_mode
);

  p_latch_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15]) |=> (mirror_mode == $past(cpu_data[7:6])));

  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15]) |=> $stable(mirror_mode));

  p_half_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && cpu_data[5]) |=>
      (prg_bank == BW'($past(cpu_data) & 8'h1F)));

  p_full_a14_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && !cpu_data[5]) |=> (prg_bank[0] == cpu_addr[14]));

  p_tri_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_mode == 2'd0) |-> (nt_screen == (ppu_quad == 2'd3)));

  p_vert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_mode == 2'd1) |-> (nt_screen == ppu_quad[0]));

  p_horz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_mode == 2'd2) |-> (nt_screen == ppu_quad[1]));

  p_solo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_mode == 2'd3) |-> nt_screen);

endmodule

bind prg_mirror_latch prgmir_checker #(.BW(BANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_data    (cpu_data),
  .cpu_wr      (cpu_wr),
  .ppu_quad    (ppu_quad),
  .prg_bank    (prg_bank),
  .nt_screen   (nt_screen),
  .mirror_mode (mirror_mode)
);

// File: tb/prg_mirror_latch_test.sv
module prg_mirror_latch_test;

  localparam int NB = 16;
  localparam int BW = $clog2(NB);

  typedef struct {
    logic [BW-1:0] prg;
    logic          scr;
    logic [1:0]    mode;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   cpu_addr;
  logic [7:0]    cpu_data;
  logic          cpu_wr;
  logic [1:0]    ppu_quad;
  logic [BW-1:0] prg_bank;
  logic          nt_screen;
  logic [1:0]    mirror_mode;

  exp_t sb_q[$];
  event probe_ev;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  logic [7:0] model_reg;

  always #10 clk = ~clk;  // 50 MHz

  prg_mirror_latch #(.PRG_BANKS16(NB)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_quad(ppu_quad), .prg_bank(prg_bank),
    .nt_screen(nt_screen), .mirror_mode(mirror_mode)
  );

  function automatic exp_t model(logic [7:0] r, logic a14, logic [1:0] q, string tag);
    exp_t e;
    logic [4:0] f;
    f = r[5] ? r[4:0] : {r[4:1], a14};
    e.prg  = f[BW-1:0];
    e.mode = r[7:6];
    case (r[7:6])
      2'd0:    e.scr = (q == 2'd3);
      2'd1:    e.scr = q[0];
      2'd2:    e.scr = q[1];
      default: e.scr = 1'b1;
    endcase
    e.tag = tag;
    return e;
  endfunction

  // Monitor: pops one expected item per probe and compares.
  initial begin
    forever begin
      @(probe_ev);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (prg_bank !== e.prg || nt_screen !== e.scr || mirror_mode !== e.mode) begin
          n_fail++;
          $display("FAIL %s: got prg=%0d scr=%0b mode=%0d, expected prg=%0d scr=%0b mode=%0d",
                   e.tag, prg_bank, nt_screen, mirror_mode, e.prg, e.scr, e.mode);
        end
      end
    end
  end

  // Sweep all quadrants and both window halves with no clock edge in between (R10).
  task automatic sweep(string tag);
    for (int h = 0; h < 2; h++) begin
      for (int q = 0; q < 4; q++) begin
        cpu_addr[14] = h[0];
        ppu_quad     = q[1:0];
        #2;
        sb_q.push_back(model(model_reg, h[0], q[1:0], tag));
        -> probe_ev;
        #1;
      end
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d, logic strobe);
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    cpu_wr   = strobe;
    @(posedge clk);
    if (strobe && a[15]) model_reg = d;
    @(negedge clk);
    cpu_wr   = 1'b0;
    cpu_addr = 16'h0000;
    cpu_data = 8'h00;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_data = '0; cpu_wr = 1'b0; ppu_quad = '0;
    model_reg = 8'h00;
    repeat (3) @(negedge clk);
    sweep("R9 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R9 after release");

    cpu_write(16'h8000, 8'h25, 1'b1);   // 16K bank 5, mode 0
    sweep("R1 R3 R5 R10");
    cpu_write(16'hFFFF, 8'h5A, 1'b1);   // 32K bank 13 -> wraps, vertical
    sweep("R4 R6");
    cpu_write(16'h7FFF, 8'hFF, 1'b1);   // below window: ignored
    sweep("R2 low address");
    cpu_write(16'hC000, 8'hB3, 1'b1);   // 16K bank 19 -> 3, horizontal
    sweep("R3 wrap R7");
    cpu_write(16'h9000, 8'h00, 1'b0);   // no strobe: ignored
    sweep("R2 no strobe");
    cpu_write(16'hA000, 8'hC0, 1'b1);   // 32K bank 0, single screen 1
    sweep("R4 R8");
    cpu_write(16'hE123, 8'h1F, 1'b1);   // 32K bank 15 -> 7, mode 0
    sweep("R4 wrap R5");

    @(negedge clk);
    rst_n = 1'b0;
    model_reg = 8'h00;
    #3;
    sweep("R9 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    #5;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule